// File: doc/BRIEF.md
# DDS Serial Configuration Sequencer

This block programs an external direct digital synthesis device over a write-only SPI link. Each transfer is one 16-bit command word. A command port accepts an operation code, a bank select and a value. It turns each command into one or more framed SPI words and raises `busy` until the last word has left the wire. Control-bit operations use a read-modify-write of an internal shadow copy of the device control word, so each update sends the whole merged word.

Frequency loads split a 28-bit tuning word into two 14-bit halves. The halves are preceded by a mode word and tagged with a bank address. Phase loads send one word carrying a 12-bit offset. An initialisation command resets the device, clears all four tuning and phase registers, and then releases reset. The output frequency is the tuning word times the master clock over 2^28. At 50 MHz, a word of 42949673 gives 8 MHz.

Top module: `dds_cfg_seq`

## Requirements
- R1: Each SPI word is 16 bits, sent MSB first. `spi_sclk` idles high. `spi_cs_n` is low for the whole word and rises only after the 16th bit's rising clock edge. `spi_mosi` changes only when `spi_sclk` rises, so it is stable while `spi_sclk` is low.
- R2: Between two words `spi_cs_n` stays high for at least `CS_GAP` system clocks. `spi_sclk` is high whenever `spi_cs_n` is high.
- R3: Frequency load (op 1) sends three words. The first is 0x2000. The second is prefix|value[13:0] and the third is prefix|value[27:14]. The prefix is 0x4000 when `cmd_bank`=0 and 0x8000 when `cmd_bank`=1.
- R4: Phase load (op 2) sends one word. It is 0xC000 (`cmd_bank`=0) or 0xE000 (`cmd_bank`=1) ORed with value[11:0]. Value bits above 11 have no effect.
- R5: Ops 3 (reset bit 0x0100), 4 (frequency-select bit 0x0800) and 5 (phase-select bit 0x0400) set the bit in the shadow word when value[0]=1 and clear it when value[0]=0. Each op then sends the whole shadow word once. Other value bits have no effect.
- R6: Sign-output op 7 clears mask 0x003A in the shadow word, then ORs in a code chosen by value[1:0]: 0→0x0000, 1→0x0028, 2→0x0020, 3→0x0038. It then sends the shadow word.
- R7: Waveform op 6 with value[0]=1 (triangle) clears mask 0x003A and ORs in 0x0002. With value[0]=0 (sine) it clears only bit 0x0002. Either way it then sends the shadow word.
- R8: Init op 0 sets the reset bit and sends the shadow word twice. It then sends 0x2000,0x4000,0x4000, then 0x2000,0x8000,0x8000, then 0xC000, then 0xE000. Finally it clears the reset bit and sends the shadow word: 11 words in all.
- R9: The shadow word is 0x0000 after reset. The 0x2000 mode word sent by frequency loads is never merged into it.
- R10: `cmd_ack` equals `cmd_req` while `busy` is low, and a command is taken in that cycle. `busy` is high from the next cycle until the last word's chip-select gap ends. While `busy` is high, `cmd_ack` stays low and requests are ignored.
- R11: During and right after reset, `spi_cs_n`=1, `spi_sclk`=1 and `busy`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_req | input | 1 | Command request |
| cmd_op | input | 3 | Operation code (0 init, 1 freq, 2 phase, 3 reset bit, 4 freq select, 5 phase select, 6 waveform, 7 sign output) |
| cmd_bank | input | 1 | Register bank for frequency and phase loads |
| cmd_val | input | 28 | Operation value |
| cmd_ack | output | 1 | Command accepted this cycle |
| busy | output | 1 | Sequence in progress |
| spi_sclk | output | 1 | SPI clock, idles high |
| spi_mosi | output | 1 | SPI serial data |
| spi_cs_n | output | 1 | SPI chip select, active low |

## Verification
A corrupted shadow word shows up in the very next control-op word. It also shows in the final word of an init run, so a stale or wrongly merged bit is caught on the first command that reads it back. A step counter or word selector that is off by one shows as a word out of place in the captured stream, or a missing or extra word, seen at the next chip-select rise. A serialiser fault shows within one word: a wrong bit count, swapped bit order, data moving while the clock is low, or a chip-select gap that is too short.

// File: rtl/dds_cfg_pkg.sv
// Package: shared opcodes, command-word constants and field widths for the
// DDS configuration sequencer. Assumes a 16-bit device command word.
package dds_cfg_pkg;
    localparam int WORD_W  = 16;
    localparam int FREQ_W  = 28;
    localparam int HALF_W  = FREQ_W / 2;
    localparam int PHASE_W = 12;

    typedef enum logic [2:0] {
        OP_INIT  = 3'd0,
        OP_FREQ  = 3'd1,
        OP_PHASE = 3'd2,
        OP_RST   = 3'd3,
        OP_FSEL  = 3'd4,
        OP_PSEL  = 3'd5,
        OP_WAVE  = 3'd6,
        OP_SIGN  = 3'd7
    } dds_op_e;

    localparam logic [WORD_W-1:0] CTL_RESET = 16'h0100;
    localparam logic [WORD_W-1:0] CTL_PSEL  = 16'h0400;
    localparam logic [WORD_W-1:0] CTL_FSEL  = 16'h0800;
    localparam logic [WORD_W-1:0] CTL_MASK  = 16'h003A;
    localparam logic [WORD_W-1:0] CTL_TRI   = 16'h0002;
    localparam logic [WORD_W-1:0] W_FMODE   = 16'h2000;
    localparam logic [WORD_W-1:0] PFX_F0    = 16'h4000;
    localparam logic [WORD_W-1:0] PFX_F1    = 16'h8000;
    localparam logic [WORD_W-1:0] PFX_P0    = 16'hC000;
    localparam logic [WORD_W-1:0] PFX_P1    = 16'hE000;

    // Map a 2-bit sign-output selector to its control-word code.
    function automatic logic [WORD_W-1:0] sign_code(input logic [1:0] sel);
        case (sel)
            2'd1:    sign_code = 16'h0028;
            2'd2:    sign_code = 16'h0020;
            2'd3:    sign_code = 16'h0038;
            default: sign_code = 16'h0000;
        endcase
    endfunction
endpackage

// File: rtl/dds_spi_tx.sv
// Module: SPI mode-2 word serialiser. It shifts one WORD_W-bit word MSB first.
// The clock idles high, data changes on the rising edge and the device
// samples on the falling edge. Chip select rises half a clock period after
// the last rising edge and then stays high for CS_GAP system clocks or more.
// Assumes: SCLK_DIV is even and >= 2, CS_GAP >= 2, and start is only
// pulsed while ready is high.
module dds_spi_tx
    import dds_cfg_pkg::*;
#(
    parameter int SCLK_DIV = 4,
    parameter int CS_GAP   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] word,
    output logic              ready,
    output logic              sclk,
    output logic              mosi,
    output logic              cs_n
);
    localparam int HALF = SCLK_DIV / 2;
    localparam int DVW  = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int GW   = $clog2(CS_GAP + 1);
    localparam int BCW  = $clog2(WORD_W);

    typedef enum logic [1:0] {TX_IDLE, TX_SHIFT, TX_TAIL, TX_GAP} tx_state_e;

    tx_state_e         state;
    logic [WORD_W-1:0] sreg;
    logic [BCW-1:0]    bit_cnt;
    logic [DVW-1:0]    div_cnt;
    logic [GW-1:0]     gap_cnt;

    // Frame control: load the word, toggle the clock, shift, then enforce the gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= TX_IDLE;
            sreg    <= '0;
            bit_cnt <= '0;
            div_cnt <= '0;
            gap_cnt <= '0;
            sclk    <= 1'b1;
            cs_n    <= 1'b1;
        end else begin
            case (state)
                TX_IDLE: if (start) begin
                    sreg    <= word;
                    cs_n    <= 1'b0;
                    bit_cnt <= '0;
                    div_cnt <= '0;
                    state   <= TX_SHIFT;
                end
                TX_SHIFT: if (div_cnt == DVW'(HALF - 1)) begin
                    div_cnt <= '0;
                    if (sclk) begin
                        sclk <= 1'b0;
                    end else begin
                        sclk <= 1'b1;
                        if (bit_cnt == BCW'(WORD_W - 1)) begin
                            state <= TX_TAIL;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                            sreg    <= {sreg[WORD_W-2:0], 1'b0};
                        end
                    end
                end else begin
                    div_cnt <= div_cnt + 1'b1;
                end
                TX_TAIL: if (div_cnt == DVW'(HALF - 1)) begin
                    div_cnt <= '0;
                    cs_n    <= 1'b1;
                    gap_cnt <= GW'(1);
                    state   <= TX_GAP;
                end else begin
                    div_cnt <= div_cnt + 1'b1;
                end
                default: if (gap_cnt >= GW'(CS_GAP)) begin
                    state <= TX_IDLE;
                end else begin
                    gap_cnt <= gap_cnt + 1'b1;
                end
            endcase
        end
    end

    assign mosi  = sreg[WORD_W-1];
    assign ready = (state == TX_IDLE);
endmodule

// File: rtl/dds_cmd_seq.sv
// Module: command sequencer. It accepts one command while idle, keeps the
// shadow control word, and hands the serialiser one word at a time.
// Assumes the serialiser drops ready in the cycle after a start pulse.
module dds_cmd_seq
    import dds_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_req,
    input  logic [2:0]        cmd_op,
    input  logic              cmd_bank,
    input  logic [FREQ_W-1:0] cmd_val,
    input  logic              tx_ready,
    output logic              cmd_ack,
    output logic              busy,
    output logic              tx_start,
    output logic [WORD_W-1:0] tx_word
);
    localparam int INIT_WORDS = 11;
    localparam int SW = $clog2(INIT_WORDS + 1);

    dds_op_e           op_q;
    logic              bank_q;
    logic [FREQ_W-1:0] val_q;
    logic [SW-1:0]     step;
    logic [SW-1:0]     nsteps;
    logic [WORD_W-1:0] shadow;
    logic [WORD_W-1:0] word_cur;
    logic [WORD_W-1:0] fpfx;

    // Merge one control operation into the shadow word.
    function automatic logic [WORD_W-1:0] ctl_next(input logic [WORD_W-1:0] s,
                                                   input dds_op_e op,
                                                   input logic [1:0] v);
        case (op)
            OP_INIT: ctl_next = s | CTL_RESET;
            OP_RST:  ctl_next = v[0] ? (s | CTL_RESET) : (s & ~CTL_RESET);
            OP_FSEL: ctl_next = v[0] ? (s | CTL_FSEL)  : (s & ~CTL_FSEL);
            OP_PSEL: ctl_next = v[0] ? (s | CTL_PSEL)  : (s & ~CTL_PSEL);
            OP_WAVE: ctl_next = v[0] ? ((s & ~CTL_MASK) | CTL_TRI) : (s & ~CTL_TRI);
            OP_SIGN: ctl_next = (s & ~CTL_MASK) | sign_code(v);
            default: ctl_next = s;
        endcase
    endfunction

    assign cmd_ack = cmd_req && !busy;
    assign fpfx    = bank_q ? PFX_F1 : PFX_F0;

    // Select the word for the current step of the active operation.
    always_comb begin
        word_cur = shadow;
        case (op_q)
            OP_INIT: case (step)
                SW'(2), SW'(5): word_cur = W_FMODE;
                SW'(3), SW'(4): word_cur = PFX_F0;
                SW'(6), SW'(7): word_cur = PFX_F1;
                SW'(8):         word_cur = PFX_P0;
                SW'(9):         word_cur = PFX_P1;
                SW'(10):        word_cur = shadow & ~CTL_RESET;
                default:        word_cur = shadow;
            endcase
            OP_FREQ: case (step)
                SW'(0):  word_cur = W_FMODE;
                SW'(1):  word_cur = fpfx | WORD_W'(val_q[HALF_W-1:0]);
                default: word_cur = fpfx | WORD_W'(val_q[FREQ_W-1:HALF_W]);
            endcase
            OP_PHASE: word_cur = (bank_q ? PFX_P1 : PFX_P0) | WORD_W'(val_q[PHASE_W-1:0]);
            default:  word_cur = shadow;
        endcase
    end

    // Accept commands, update the shadow word and issue words in order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            op_q     <= OP_INIT;
            bank_q   <= 1'b0;
            val_q    <= '0;
            step     <= '0;
            nsteps   <= '0;
            shadow   <= '0;
            tx_start <= 1'b0;
            tx_word  <= '0;
        end else begin
            tx_start <= 1'b0;
            if (cmd_ack) begin
                op_q   <= dds_op_e'(cmd_op);
                bank_q <= cmd_bank;
                val_q  <= cmd_val;
                step   <= '0;
                busy   <= 1'b1;
                shadow <= ctl_next(shadow, dds_op_e'(cmd_op), cmd_val[1:0]);
                case (dds_op_e'(cmd_op))
                    OP_INIT: nsteps <= SW'(INIT_WORDS);
                    OP_FREQ: nsteps <= SW'(3);
                    default: nsteps <= SW'(1);
                endcase
            end else if (busy && tx_ready && !tx_start) begin
                if (step == nsteps) begin
                    busy <= 1'b0;
                end else begin
                    tx_start <= 1'b1;
                    tx_word  <= word_cur;
                    step     <= step + 1'b1;
                    if (op_q == OP_INIT && step == SW'(INIT_WORDS - 1))
                        shadow <= shadow & ~CTL_RESET;
                end
            end
        end
    end
endmodule

// File: rtl/dds_cfg_seq.sv
// Module: top of the DDS configuration sequencer. It joins the command
// sequencer to the SPI mode-2 serialiser.
// Assumes: SCLK_DIV is even and >= 2, CS_GAP >= 2.
module dds_cfg_seq
    import dds_cfg_pkg::*;
#(
    parameter int SCLK_DIV = 4,
    parameter int CS_GAP   = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_req,
    input  logic [2:0]  cmd_op,
    input  logic        cmd_bank,
    input  logic [27:0] cmd_val,
    output logic        cmd_ack,
    output logic        busy,
    output logic        spi_sclk,
    output logic        spi_mosi,
    output logic        spi_cs_n
);
    logic              tx_ready;
    logic              tx_start;
    logic [WORD_W-1:0] tx_word;

    dds_cmd_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_req  (cmd_req),
        .cmd_op   (cmd_op),
        .cmd_bank (cmd_bank),
        .cmd_val  (cmd_val),
        .tx_ready (tx_ready),
        .cmd_ack  (cmd_ack),
        .busy     (busy),
        .tx_start (tx_start),
        .tx_word  (tx_word)
    );

    dds_spi_tx #(.SCLK_DIV(SCLK_DIV), .CS_GAP(CS_GAP)) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tx_start),
        .word  (tx_word),
        .ready (tx_ready),
        .sclk  (spi_sclk),
        .mosi  (spi_mosi),
        .cs_n  (spi_cs_n)
    );
endmodule

// File: rtl/dds_cfg_seq_chk.sv
// Module: port-level checker for dds_cfg_seq, attached with bind.
// Assumes it sees the top's ports and its CS_GAP parameter.
module dds_cfg_seq_chk #(
    parameter int CS_GAP = 2
) (
    input logic clk,
    input logic rst_n,
    input logic cmd_ack,
    input logic busy,
    input logic spi_sclk,
    input logic spi_mosi,
    input logic spi_cs_n
);
    logic [15:0] hi_cnt;

    // Count consecutive chip-select-high cycles, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)            hi_cnt <= 16'hFFFF;
        else if (!spi_cs_n)    hi_cnt <= '0;
        else if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 1'b1;
    end

    AST_MOSI_STABLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_sclk |-> $stable(spi_mosi)); // R1
    AST_SCLK_HIGH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> spi_sclk); // R2
    AST_CS_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> (32'(hi_cnt) >= CS_GAP)); // R2
    AST_ACK_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ack |-> !busy); // R10
    AST_ACK_THEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ack |=> busy); // R10
    AST_IDLE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> spi_cs_n); // R10
endmodule

bind dds_cfg_seq dds_cfg_seq_chk #(.CS_GAP(CS_GAP)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_ack  (cmd_ack),
    .busy     (busy),
    .spi_sclk (spi_sclk),
    .spi_mosi (spi_mosi),
    .spi_cs_n (spi_cs_n)
);

// File: tb/dds_cfg_seq_test.sv
// Bench: drives every opcode over a spread of values, decodes the SPI
// stream and compares each word against an arithmetic model.
module dds_cfg_seq_test;
    localparam int GAP = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_req = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic        cmd_bank = 1'b0;
    logic [27:0] cmd_val = '0;
    logic        cmd_ack, busy, spi_sclk, spi_mosi, spi_cs_n;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    logic [15:0] exp_q[$];
    logic [15:0] shadow_m = 16'h0000;
    string       cur_tag = "R11";

    dds_cfg_seq #(.SCLK_DIV(2), .CS_GAP(GAP)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_req(cmd_req), .cmd_op(cmd_op),
        .cmd_bank(cmd_bank), .cmd_val(cmd_val), .cmd_ack(cmd_ack), .busy(busy),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Watchdog: a hung run is counted as one failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // SPI monitor: capture bits on falling SCLK, check each word when CS rises.
    logic        prev_sclk = 1'b1, prev_cs = 1'b1;
    logic [15:0] rx = '0;
    int          nbits = 0;
    int          hi_cnt = 100;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!spi_cs_n && prev_sclk && !spi_sclk) begin
                rx = {rx[14:0], spi_mosi};
                nbits++;
            end
            if (prev_cs && !spi_cs_n) begin
                chk(hi_cnt >= GAP, "R2 cs gap", hi_cnt, GAP);
                nbits = 0;
            end
            if (!prev_cs && spi_cs_n) begin
                chk(nbits == 16, "R1 bit count", nbits, 16);
                if (exp_q.size() == 0) begin
                    chk(1'b0, {cur_tag, " unexpected word"}, int'(rx), 0);
                end else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    chk(rx == e, cur_tag, int'(rx), int'(e));
                end
            end
            hi_cnt = spi_cs_n ? hi_cnt + 1 : 0;
            prev_sclk = spi_sclk;
            prev_cs = spi_cs_n;
        end
    end

    // Model of the shadow word after a control op.
    function automatic logic [15:0] ctl_model(input logic [15:0] s, input int op, input logic [27:0] v);
        logic [15:0] code;
        case (v[1:0])
            2'd1: code = 16'h0028;
            2'd2: code = 16'h0020;
            2'd3: code = 16'h0038;
            default: code = 16'h0000;
        endcase
        case (op)
            3: return v[0] ? (s | 16'h0100) : (s & ~16'h0100);
            4: return v[0] ? (s | 16'h0800) : (s & ~16'h0800);
            5: return v[0] ? (s | 16'h0400) : (s & ~16'h0400);
            6: return v[0] ? ((s & ~16'h003A) | 16'h0002) : (s & ~16'h0002);
            7: return (s & ~16'h003A) | code;
            default: return s;
        endcase
    endfunction

    task automatic push_freq(input bit bank, input logic [27:0] v);
        logic [15:0] p;
        p = bank ? 16'h8000 : 16'h4000;
        exp_q.push_back(16'h2000);
        exp_q.push_back(p | 16'(v % 28'd16384));
        exp_q.push_back(p | 16'(v / 28'd16384));
    endtask

    // Issue one command, check the handshake, then wait for completion.
    task automatic run(input int op, input bit bank, input logic [27:0] v, input string tag);
        cur_tag = tag;
        case (op)
            0: begin
                shadow_m = shadow_m | 16'h0100;
                exp_q.push_back(shadow_m);
                exp_q.push_back(shadow_m);
                push_freq(1'b0, 28'd0);
                push_freq(1'b1, 28'd0);
                exp_q.push_back(16'hC000);
                exp_q.push_back(16'hE000);
                shadow_m = shadow_m & ~16'h0100;
                exp_q.push_back(shadow_m);
            end
            1: push_freq(bank, v);
            2: exp_q.push_back((bank ? 16'hE000 : 16'hC000) | 16'(v % 28'd4096));
            default: begin
                shadow_m = ctl_model(shadow_m, op, v);
                exp_q.push_back(shadow_m);
            end
        endcase
        @(negedge clk);
        cmd_req = 1'b1; cmd_op = 3'(op); cmd_bank = bank; cmd_val = v;
        #1 chk(cmd_ack == 1'b1, "R10 ack while idle", int'(cmd_ack), 1);
        @(negedge clk);
        cmd_op = 3'd0; cmd_val = 28'hFFFFFFF;
        #1 chk(busy == 1'b1 && cmd_ack == 1'b0, "R10 busy and no ack", int'({busy, cmd_ack}), 2);
        @(negedge clk);
        cmd_req = 1'b0;
        while (busy) @(negedge clk);
        chk(exp_q.size() == 0, {tag, " word count"}, exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(spi_cs_n && spi_sclk && !busy, "R11 in reset", int'({spi_cs_n, spi_sclk, busy}), 6);
        rst_n = 1'b1;
        @(negedge clk);
        chk(spi_cs_n && spi_sclk && !busy && !cmd_ack, "R11 after reset", int'({spi_cs_n, spi_sclk, busy}), 6);

        run(0, 1'b0, 28'd0, "R8 init");
        run(4, 1'b0, 28'd1, "R9 fsel from zero shadow");
        run(4, 1'b0, 28'hFFFFFFE, "R5 fsel clear, high bits ignored");
        // R3 frequency loads over several values and both banks
        for (int b = 0; b < 2; b++) begin
            run(1, b[0], 28'd0, "R3 freq zero");
            run(1, b[0], 28'd42949673, "R3 freq 8MHz word");
            run(1, b[0], 28'hFFFFFFF, "R3 freq all ones");
            run(1, b[0], 28'h0003FFF, "R3 freq low half full");
            run(1, b[0], 28'h0004000, "R3 freq upper half lsb");
        end
        // R4 phase loads
        for (int b = 0; b < 2; b++) begin
            run(2, b[0], 28'd0, "R4 phase zero");
            run(2, b[0], 28'h0000FFF, "R4 phase full");
            run(2, b[0], 28'hABC15A5, "R4 phase high bits ignored");
        end
        // R5 each control bit set then clear
        for (int op = 3; op <= 5; op++) begin
            run(op, 1'b0, 28'd1, "R5 bit set");
            run(op, 1'b0, 28'hFFFFFF1, "R5 bit set again");
            run(op, 1'b0, 28'd0, "R5 bit clear");
        end
        run(4, 1'b0, 28'd1, "R5 fsel held");
        // R6 all sign codes, R7 waveform interaction
        for (int c = 0; c < 4; c++) run(7, 1'b0, 28'(c), "R6 sign code");
        run(7, 1'b0, 28'd1, "R6 sign msb");
        run(6, 1'b0, 28'd1, "R7 triangle clears sign mask");
        run(6, 1'b0, 28'd0, "R7 sine clears only mode bit");
        run(7, 1'b0, 28'd3, "R6 comparator");
        run(6, 1'b0, 28'd0, "R7 sine keeps sign bits");
        run(1, 1'b1, 28'd5, "R3 freq between control ops");
        run(5, 1'b0, 28'd1, "R9 mode word not merged");
        run(0, 1'b0, 28'd0, "R8 init keeps other bits");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule